// File: doc/BRIEF.md
# Dual-Select Asynchronous Static Memory Target

This block is the memory side of an asynchronous byte-wide static RAM for use inside a chip. An external or on-chip initiator drives an address, write data, two chip selects of opposite polarity (one active low, one active high), an active-low write strobe and an active-low output enable. The data bus is split into an input byte, an output byte and an output-drive flag, so a pad or tristate wrapper can rebuild the shared bus.

All strobes, the address and the write data pass through two-flop synchronizers clocked by the system clock. The block works out its mode from the synchronized controls and reports it. It drives the addressed byte only while reading. It writes the array once, when the sampled write overlap (strobe low while both selects are active) goes from true to false. The overlap can be closed by any of the three qualifying signals. The address and data stored are the ones sampled in the last cycle of the overlap.

The word count is `2**ADDR_W`. Setting `ADDR_W` to 17 gives the full 128K x 8 organization. The default is smaller so the array stays light when elaborated.

Top module: `sram_async_target`

## Requirements
- R1: After reset, `mode` is 0, `dq_oe` is 0 and `dq_out` is 0.
- R2: When `cs1_n` is 1 or `cs2` is 0, `mode` is 0 (standby) and `dq_oe` is 0, whatever `we_n` and `oe_n` do. Toggling `we_n` in this state leaves the stored data unchanged.
- R3: When selected (`cs1_n`=0 and `cs2`=1) with `we_n`=0, `mode` is 2 (write) and `dq_oe` is 0, even when `oe_n` is 0.
- R4: One array write happens when the sampled overlap of `we_n`=0, `cs1_n`=0 and `cs2`=1 ends. The write happens whether the overlap is ended by `we_n` rising, `cs1_n` rising or `cs2` falling.
- R5: The byte written and its location are the `din` and `addr` sampled in the last cycle of the overlap. An address or data change made at the same moment as the closing edge does not affect the write.
- R6: When selected with `we_n`=1 and `oe_n`=0, `mode` is 1 (read), `dq_oe` is 1 and `dq_out` is the stored byte at `addr`.
- R7: When selected with `we_n`=1 and `oe_n`=1, `mode` is 3 (selected idle) and `dq_oe` is 0. Whenever `dq_oe` is 0, `dq_out` is 0.
- R8: A change on the control inputs shows on `mode` at the second rising clock edge after it, and not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data from the bus |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_out | output | 8 | Read data toward the bus |
| dq_oe | output | 1 | High when the block drives the bus |
| mode | output | 2 | 0 standby, 1 read, 2 write, 3 selected idle |

## Verification
The assertions check on every cycle that the bus is never driven while the block is deselected or while a write strobe is active. They also check that the write address holds still outside an overlap, and that each commit uses the address sampled in the overlap's last cycle. Only the bench's scenarios can show that data actually lands in the array for each of the three ways to close a write, and that deselected strobes leave the stored byte intact. The bench also shows the exact two-edge delay and that a late address change does not redirect a write.

// File: rtl/sram_async_target.sv
module sram_async_target #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              we_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [1:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] M_STBY = 2'd0, M_READ = 2'd1, M_WRITE = 2'd2, M_IDLE = 2'd3;

  logic [3:0]        ctl_m, ctl_s;
  logic [ADDR_W-1:0] addr_m, addr_s, wa;
  logic [DATA_W-1:0] din_m, din_s, wd;
  logic              ovl_q;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_m  <= 4'b1011;
      ctl_s  <= 4'b1011;
      addr_m <= '0;
      addr_s <= '0;
      din_m  <= '0;
      din_s  <= '0;
    end else begin
      ctl_m  <= {cs1_n, cs2, we_n, oe_n};
      ctl_s  <= ctl_m;
      addr_m <= addr;
      addr_s <= addr_m;
      din_m  <= din;
      din_s  <= din_m;
    end
  end

  wire s_cs1_n = ctl_s[3];
  wire s_cs2   = ctl_s[2];
  wire s_we_n  = ctl_s[1];
  wire s_oe_n  = ctl_s[0];
  wire sel     = !s_cs1_n && s_cs2;
  wire ovl     = sel && !s_we_n;
  wire commit  = ovl_q && !ovl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q <= 1'b0;
      wa    <= '0;
      wd    <= '0;
    end else begin
      ovl_q <= ovl;
      if (ovl) begin
        wa <= addr_s;
        wd <= din_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wa] <= wd;
  end

  assign mode   = !sel    ? M_STBY  :
                  !s_we_n ? M_WRITE :
                  !s_oe_n ? M_READ  : M_IDLE;
  assign dq_oe  = (mode == M_READ);
  assign dq_out = dq_oe ? mem[addr_s] : '0;

  assert_no_drive_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs1_n || !s_cs2) |-> !dq_oe);
  assert_no_drive_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_we_n |-> !dq_oe);
  assert_commit_last_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wa == $past(addr_s)));
  assert_hold_outside_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl |=> $stable(wa));
endmodule

// File: tb/sram_async_target_bench.sv
module sram_async_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0]    dq_out;
  logic          dq_oe;
  logic [1:0]    mode;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_target #(.ADDR_W(AW)) u_sram_async_target (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cs1_n(cs1_n), .cs2(cs2),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic deselect();
    @(negedge clk);
    cs1_n = 1'b1; cs2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    settle();
  endtask

  // kind: 0 we_n rises, 1 cs1_n rises, 2 cs2 falls
  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input int kind);
    @(negedge clk);
    addr = a; din = d; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    settle();
    chk("R3 write mode", mode, 2);
    chk("R3 no drive in write", dq_oe, 0);
    @(negedge clk);
    if (kind == 0) we_n = 1'b1;
    else if (kind == 1) cs1_n = 1'b1;
    else cs2 = 1'b0;
    settle();
    deselect();
  endtask

  task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    settle();
    chk({tag, " mode"}, mode, 1);
    chk({tag, " oe"}, dq_oe, 1);
    chk({tag, " data"}, dq_out, exp);
    deselect();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 mode", mode, 0);
    chk("R1 oe", dq_oe, 0);
    chk("R1 data", dq_out, 0);
  endtask

  task automatic t_commit_edges();
    do_write(11'h012, 8'hA5, 0);
    read_chk("R4 we_n close", 11'h012, 8'hA5);
    do_write(11'h345, 8'h3C, 1);
    read_chk("R4 cs1_n close", 11'h345, 8'h3C);
    do_write(11'h7FF, 8'hC3, 2);
    read_chk("R4 cs2 close", 11'h7FF, 8'hC3);
    read_chk("R6 read again", 11'h012, 8'hA5);
  endtask

  task automatic t_deselected();
    do_write(11'h100, 8'h11, 0);
    @(negedge clk);
    addr = 11'h100; din = 8'h99; cs1_n = 1'b0; cs2 = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    settle();
    chk("R2 standby cs2 low", mode, 0);
    chk("R2 no drive cs2 low", dq_oe, 0);
    @(negedge clk); we_n = 1'b1; settle();
    @(negedge clk); cs1_n = 1'b1; cs2 = 1'b1; we_n = 1'b0; settle();
    chk("R2 standby cs1_n high", mode, 0);
    chk("R2 no drive cs1_n high", dq_oe, 0);
    @(negedge clk); we_n = 1'b1; settle();
    deselect();
    read_chk("R2 data kept", 11'h100, 8'h11);
  endtask

  task automatic t_late_change();
    do_write(11'h200, 8'h5A, 0);
    @(negedge clk);
    addr = 11'h201; din = 8'h77; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b0; oe_n = 1'b1;
    settle();
    @(negedge clk);
    we_n = 1'b1; addr = 11'h200; din = 8'hEE;
    settle();
    deselect();
    read_chk("R5 target", 11'h201, 8'h77);
    read_chk("R5 other kept", 11'h200, 8'h5A);
  endtask

  task automatic t_idle();
    @(negedge clk);
    addr = 11'h012; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    settle();
    chk("R7 idle mode", mode, 3);
    chk("R7 no drive", dq_oe, 0);
    chk("R7 data zero", dq_out, 0);
    deselect();
  endtask

  task automatic t_latency();
    @(negedge clk);
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1;
    chk("R8 first edge", mode, 0);
    @(posedge clk); #1;
    chk("R8 second edge", mode, 1);
    deselect();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    settle();
    t_commit_edges();
    t_deselected();
    t_late_change();
    t_idle();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule